// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits on a fast source clock and produces a set of gated copies of it. A single asynchronous, active-low stop request turns all copies off together. The request is brought into the source clock domain by a short flop chain. The gating enable of every output is then changed only while the source clock is low. As a result a stopped output always rests low, and a restarted output begins with a complete high phase. Short or truncated pulses cannot occur.

Once the outputs start running, a hold window keeps them running for a minimum number of source cycles. A stop request that arrives inside that window is deferred for as long as the request stays asserted. It takes effect at the first cycle after the window ends. A request that is withdrawn before the window ends is dropped. Each output also has its own enable bit. The bit comes from a register in the same clock domain and changes only just after a rising source edge. A cleared bit holds that one output low and does not affect the others. A status flag reports whether the outputs are in the running state.

Top module: `clkstop_gate`

## Requirements
- R1: While reset is asserted, every gated output and the running flag are 0. After reset is released with the stop request inactive (high), the first gated high pulse comes on the third source rising edge after release.
- R2: When the stop request falls and the hold window has expired, the outputs pass at most two more high pulses. The third source rising edge after the request changes is suppressed.
- R3: When the stop request rises while stopped, the first gated high pulse comes on the third source rising edge after the request changes.
- R4: Throughout the low phase of the source clock every gated output is 0, and a stopped output stays 0 during both phases.
- R5: Every gated high pulse lasts exactly half a source period. The gating enable changes only while the source clock is low.
- R6: After a restart, the running state lasts for at least MIN_ON (default 100) source rising edges before a stop may suppress a pulse.
- R7: A stop request seen inside the hold window, and held asserted, takes effect on the first edge after the window closes. A request withdrawn before the window closes causes no stop at all.
- R8: An enable bit at 0 holds its own output at 0 from the next source rising edge. The other outputs are not affected. Bit i of `out_en` controls bit i of `clk_out`.
- R9: The running flag is 1 exactly while the outputs are in the running state. It changes at the same source rising edge as the first restored or suppressed pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| out_en | input | N_OUT | Per-output enable bits, same clock domain, 1 = may run |
| clk_out | output | N_OUT | Gated clock outputs, low when stopped or disabled |
| running | output | 1 | 1 while the outputs are in the running state |

## Verification
On every cycle, the assertions check the following:
- The controller never leaves the running state while its hold window is still counting.
- The running state changes only in the direction the synchronized request asks for.
- A disabled output has its gate closed.
- The gating enable never moves while the source clock is high.

The bench's scenarios cover the rest. They measure the exact latencies in edges from a request change to the first suppressed or restored pulse. They show that a deferred stop lands on the edge just after the window, and that a withdrawn request is dropped. They also measure the width of every individual high pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Minimum synchronizer depth that keeps metastability out of the gate path.
  localparam int unsigned CS_SYNC_MIN = 2;

  // Width of a down-counter that must hold the value n-1.
  function automatic int unsigned cs_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES = clkstop_pkg::CS_SYNC_MIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  // Reset value 0: the synchronized request reads "stop" until the input is seen.
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_hold_ctrl.sv
module clkstop_hold_ctrl #(
  parameter int unsigned MIN_ON = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,        // synchronized request, 1 = run
  output logic run_nxt_o,   // state for the coming edge, sampled by gate cells at the falling edge
  output logic run_o        // registered running state
);

  localparam int unsigned   CW   = clkstop_pkg::cs_cnt_width(MIN_ON);
  localparam logic [CW-1:0] LOAD = CW'(MIN_ON - 1);

  logic          run_q;
  logic [CW-1:0] hold_q;
  logic          hold_busy;

  assign hold_busy = (hold_q != '0);

  // A stop is honoured only once the hold window has drained; while the
  // request remains asserted it simply waits here.
  always_comb begin
    if (run_q) run_nxt_o = go_i | hold_busy;
    else       run_nxt_o = go_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      run_q <= run_nxt_o;
      if (!run_q && run_nxt_o)  hold_q <= LOAD;
      else if (hold_busy)       hold_q <= hold_q - 1'b1;
    end
  end

  assign run_o = run_q;

  AST_HOLD_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && hold_busy) |=> run_q);                                    // R6
  AST_HOLD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= LOAD);                                                    // R6
  AST_STOP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !$past(go_i));                                     // R2
  AST_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(go_i));                                      // R3

endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic en_i,
  output logic clk_o
);

  logic gate_q;

  // Updated only on the falling edge, so the AND below never sees a change
  // while the source clock is high.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= open_i & en_i;
  end

  assign clk_o = clk_i & gate_q;

  always @(gate_q) begin
    if (rst_ni) begin
      AST_GATE_LOW_PHASE: assert (!clk_i) else $error("gate moved in high phase"); // R5
    end
  end

  AST_DISABLED_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !gate_q);                                                 // R8

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned N_OUT       = 4,
  parameter int unsigned MIN_ON      = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_out,
  output logic             running
);

  logic go_sync;
  logic run_nxt;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_src),
    .rst_ni  (rst_n),
    .async_i (stop_req_n),
    .sync_o  (go_sync)
  );

  clkstop_hold_ctrl #(.MIN_ON(MIN_ON)) u_ctrl (
    .clk_i     (clk_src),
    .rst_ni    (rst_n),
    .go_i      (go_sync),
    .run_nxt_o (run_nxt),
    .run_o     (running)
  );

  generate
    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
      clkstop_gate_cell u_cell (
        .clk_i  (clk_src),
        .rst_ni (rst_n),
        .open_i (run_nxt),
        .en_i   (out_en[gi]),
        .clk_o  (clk_out[gi])
      );
    end
  endgenerate

endmodule

// File: tb/clkstop_gate_tb_top.sv
`timescale 1ns/1ps
module clkstop_gate_tb_top;

  localparam int N      = 4;
  localparam int MIN_ON = 100;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_n = 1'b0;
  logic [N-1:0] en = '1;
  logic [N-1:0] cko;
  logic         running;

  always #2 clk = ~clk;   // 250 MHz

  clkstop_gate #(.N_OUT(N), .MIN_ON(MIN_ON)) dut_i (
    .clk_src    (clk),
    .rst_n      (rst_n),
    .stop_req_n (req_n),
    .out_en     (en),
    .clk_out    (cko),
    .running    (running)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // Requirement-level model: request seen two edges back, hold window of MIN_ON edges.
  bit   m_run = 1'b0;
  int   m_cnt = 0;
  logic h1 = 1'b0, h2 = 1'b0;

  function automatic bit model_run(input bit run, input int cnt, input logic rq_old);
    if (run) return !(rq_old == 1'b0 && cnt == 0);
    return rq_old == 1'b1;
  endfunction

  function automatic logic [N-1:0] model_out(input bit run, input logic [N-1:0] e);
    return run ? e : '0;
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h time=%0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input logic rq, input logic [N-1:0] e);
    bit r;
    @(posedge clk); #1;
    r = model_run(m_run, m_cnt, h2);
    if (!m_run && r)  m_cnt = MIN_ON - 1;
    else if (m_cnt > 0) m_cnt--;
    m_run = r;
    chk(tag, 32'(cko), 32'(model_out(r, en)));
    chk("R9", 32'(running), 32'(r));
    h2 = h1;
    h1 = req_n;
    req_n = rq;
    en    = e;
  endtask

  // R4: every output low in the source low phase
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (cko !== '0) begin
        fails++;
        $display("FAIL R4 act=%0h exp=0 time=%0t", cko, $time);
      end
    end
  end

  // R5: every high pulse is exactly half a period
  realtime      t_rise [N];
  logic [N-1:0] prev = '0;
  always @(cko) begin
    for (int i = 0; i < N; i++) begin
      if (cko[i] === 1'b1 && prev[i] !== 1'b1) t_rise[i] = $realtime;
      else if (cko[i] === 1'b0 && prev[i] === 1'b1 && !done) begin
        checks++;
        if (($realtime - t_rise[i]) < 1.99 || ($realtime - t_rise[i]) > 2.01) begin
          fails++;
          $display("FAIL R5 out=%0d width_act=%0f exp=2.0", i, $realtime - t_rise[i]);
        end
      end
    end
    prev = cko;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(cko), 32'd0);        // reset state
    chk("R1", 32'(running), 32'd0);
    rst_n = 1'b1;
    req_n = 1'b1;

    tag = "R1"; repeat (3)   step(1'b1, ALL);   // first pulse on third edge
    tag = "R6"; repeat (130) step(1'b1, ALL);
    tag = "R2"; repeat (12)  step(1'b0, ALL);   // stop after window
    tag = "R3"; repeat (20)  step(1'b1, ALL);   // restart, window reloads
    tag = "R7"; repeat (120) step(1'b0, ALL);   // deferred stop held
    tag = "R3"; repeat (5)   step(1'b1, ALL);
    tag = "R7"; repeat (10)  step(1'b0, ALL);   // withdrawn inside window
    repeat (150) step(1'b1, ALL);
    tag = "R2"; step(1'b0, ALL);                // one-cycle request after window
    repeat (12) step(1'b1, ALL);
    tag = "R8";
    repeat (10) step(1'b1, 4'b1011);
    repeat (5)  step(1'b1, 4'b0000);
    repeat (5)  step(1'b1, 4'b0100);
    repeat (5)  step(1'b1, ALL);

    tag = "R6";
    for (int c = 0; c < 3000; c++) begin
      logic         rq;
      logic [N-1:0] e;
      rq = (($urandom % 20) == 0) ? ~req_n : req_n;
      e  = (($urandom % 10) == 0) ? N'($urandom) : ALL;
      step(rq, e);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule